// File: doc/BRIEF.md
# Reseeding Pattern Sequencer for Self-Test

This block drives test stimulus for a built-in self-test by mixing stored deterministic patterns with pseudorandom expansion. A constant table holds a few seeds chosen to reach faults that random patterns rarely hit. On a start request the sequencer loads seed 0 into a linear feedback shift register (LFSR), presents that seed as the first pattern of a group, and then steps the LFSR to produce the rest of the group. When a group is complete it fetches the next seed and starts the next group. After the last group it stops and raises a done flag.

Two counters pace the run. An inner counter tracks the position inside the current group, and an outer counter holds the index of the seed in use. The state machine has three states. IDLE waits after reset. RUN emits one valid pattern per cycle. DONE holds the final pattern. The transitions are:

- launch: IDLE or DONE to RUN on start.
- reseed: RUN to RUN at the end of a group that is not the last one.
- finish: RUN to DONE at the end of the last group.

Start has no effect while the machine is in RUN.

Top module: `reseed_bist_seq`

## Requirements
- R1: While reset is low and afterwards until a start is seen, pattern_o is 0, valid_o is 0 and done_o is 0.
- R2: A start sampled in IDLE makes the next cycle valid, with pattern_o equal to seed 0. Seed i occupies bits [i*PAT_W +: PAT_W] of SEED_TABLE.
- R3: Inside a group, each pattern after the first is the previous pattern p stepped once: {p[PAT_W-2:0], parity(p & TAP_MASK)}.
- R4: Each group consists of exactly GROUP_LEN consecutive valid patterns, and its first pattern is the seed.
- R5: Seeds are used in ascending index order. The cycle after the last pattern of group i shows seed i+1.
- R6: Exactly SEED_CNT*GROUP_LEN consecutive valid cycles follow a launch. In the next cycle valid_o is 0, done_o is 1 and pattern_o still holds the last pattern. valid_o and done_o are never high together.
- R7: While done_o is high and start is low, done_o stays high and pattern_o stays unchanged.
- R8: A start asserted during RUN does not change the pattern sequence or its length.
- R9: A start sampled in DONE launches a fresh run from seed 0.
- R10: Reset during a run returns the block to IDLE with both counters at zero. The next start therefore begins again at seed 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Launch request, sampled outside RUN |
| pattern_o | output | PAT_W | Current test pattern |
| valid_o | output | 1 | pattern_o carries a test pattern this cycle |
| done_o | output | 1 | All groups have been emitted |

## Verification
The bench builds one instance with 8-bit patterns, four seeds and groups of five, and follows every one of the twenty patterns of each run against a model computed in the bench. It covers every group boundary and every transition: launch from IDLE and from DONE, a start pulse in mid-run, and a reset in mid-run. A second instance with three seeds and a group length of one covers the corner case where every pattern is a seed and the LFSR never steps.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
    typedef enum logic [1:0] {
        RBS_IDLE = 2'd0,
        RBS_RUN  = 2'd1,
        RBS_DONE = 2'd2
    } rbs_state_e;
endpackage

// File: rtl/rbs_counter.sv
module rbs_counter #(
    parameter int LIMIT = 4,
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_o <= '0;
        end else if (inc) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/rbs_seed_rom.sv
module rbs_seed_rom #(
    parameter int PAT_W    = 8,
    parameter int SEED_CNT = 4,
    parameter logic [SEED_CNT*PAT_W-1:0] SEED_TABLE = '0,
    localparam int AW = (SEED_CNT > 1) ? $clog2(SEED_CNT) : 1
) (
    input  logic [AW-1:0]    addr_i,
    output logic [PAT_W-1:0] seed_o
);
    logic [PAT_W-1:0] words [SEED_CNT];

    for (genvar i = 0; i < SEED_CNT; i++) begin : g_word
        assign words[i] = SEED_TABLE[i*PAT_W +: PAT_W];
    end

    always_comb begin
        seed_o = '0;
        for (int i = 0; i < SEED_CNT; i++) begin
            if (addr_i == AW'(i)) seed_o = words[i];
        end
    end
endmodule

// File: rtl/rbs_lfsr.sv
module rbs_lfsr #(
    parameter int PAT_W = 8,
    parameter logic [PAT_W-1:0] TAP_MASK = 8'hB8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PAT_W-1:0] load_val,
    input  logic             step,
    output logic [PAT_W-1:0] state_o
);
    logic fb;
    assign fb = ^(state_o & TAP_MASK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= '0;
        end else if (load) begin
            state_o <= load_val;
        end else if (step) begin
            state_o <= {state_o[PAT_W-2:0], fb};
        end
    end
endmodule

// File: rtl/reseed_bist_seq.sv
module reseed_bist_seq
    import rbs_pkg::*;
#(
    parameter int PAT_W     = 8,
    parameter int SEED_CNT  = 4,
    parameter int GROUP_LEN = 5,
    parameter logic [PAT_W-1:0] TAP_MASK = 8'hB8,
    parameter logic [SEED_CNT*PAT_W-1:0] SEED_TABLE = {8'h3C, 8'hE7, 8'h12, 8'h81}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic [PAT_W-1:0] pattern_o,
    output logic             valid_o,
    output logic             done_o
);
    localparam int SW = (SEED_CNT  > 1) ? $clog2(SEED_CNT)  : 1;
    localparam int RW = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;

    rbs_state_e state_q, state_d;

    logic [SW-1:0]    seed_idx;
    logic [RW-1:0]    run_pos;
    logic [SW-1:0]    rom_addr;
    logic [PAT_W-1:0] rom_seed;
    logic             run_last, seed_last;
    logic             launch, reseed, advance;

    assign run_last  = (run_pos  == RW'(GROUP_LEN - 1));
    assign seed_last = (seed_idx == SW'(SEED_CNT - 1));

    // Control decode
    assign launch  = (state_q != RBS_RUN) && start_i;
    assign reseed  = (state_q == RBS_RUN) && run_last && !seed_last;
    assign advance = (state_q == RBS_RUN) && !run_last;
    assign rom_addr = launch ? '0 : SW'(seed_idx + 1'b1);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RBS_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RBS_IDLE: if (start_i) state_d = RBS_RUN;
            RBS_RUN:  if (run_last && seed_last) state_d = RBS_DONE;
            RBS_DONE: if (start_i) state_d = RBS_RUN;
            default:  state_d = RBS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        valid_o = (state_q == RBS_RUN);
        done_o  = (state_q == RBS_DONE);
    end

    rbs_counter #(.LIMIT(GROUP_LEN)) u_run_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (launch | reseed),
        .inc   (advance),
        .cnt_o (run_pos)
    );

    rbs_counter #(.LIMIT(SEED_CNT)) u_seed_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (launch),
        .inc   (reseed),
        .cnt_o (seed_idx)
    );

    rbs_seed_rom #(
        .PAT_W      (PAT_W),
        .SEED_CNT   (SEED_CNT),
        .SEED_TABLE (SEED_TABLE)
    ) u_rom (
        .addr_i (rom_addr),
        .seed_o (rom_seed)
    );

    rbs_lfsr #(
        .PAT_W    (PAT_W),
        .TAP_MASK (TAP_MASK)
    ) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch | reseed),
        .load_val (rom_seed),
        .step     (advance),
        .state_o  (pattern_o)
    );
endmodule

// File: rtl/reseed_bist_seq_chk.sv
module reseed_bist_seq_chk #(
    parameter int PAT_W     = 8,
    parameter int SEED_CNT  = 4,
    parameter int GROUP_LEN = 5,
    parameter logic [PAT_W-1:0] TAP_MASK = 8'hB8,
    parameter logic [SEED_CNT*PAT_W-1:0] SEED_TABLE = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [PAT_W-1:0] pattern_o,
    input logic             valid_o,
    input logic             done_o
);
    logic [15:0] pos_q;
    logic [15:0] total_q;
    logic        prev_valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q        <= '0;
            total_q      <= '0;
            prev_valid_q <= 1'b0;
        end else begin
            prev_valid_q <= valid_o;
            if (!valid_o) pos_q <= '0;
            else if (pos_q == 16'(GROUP_LEN - 1)) pos_q <= '0;
            else pos_q <= pos_q + 1'b1;
            if (valid_o) total_q <= prev_valid_q ? total_q + 1'b1 : 16'd1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !done_o && pattern_o == '0));

    p_launch_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && start_i) |=> (valid_o && pattern_o == SEED_TABLE[PAT_W-1:0]));

    p_lfsr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && pos_q != '0) |->
        (pattern_o == {$past(pattern_o[PAT_W-2:0]), ^($past(pattern_o) & TAP_MASK)}));

    p_run_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (total_q == 16'(SEED_CNT * GROUP_LEN)));

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && done_o));

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(pattern_o)));
endmodule

bind reseed_bist_seq reseed_bist_seq_chk #(
    .PAT_W      (PAT_W),
    .SEED_CNT   (SEED_CNT),
    .GROUP_LEN  (GROUP_LEN),
    .TAP_MASK   (TAP_MASK),
    .SEED_TABLE (SEED_TABLE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .pattern_o (pattern_o),
    .valid_o   (valid_o),
    .done_o    (done_o)
);

// File: tb/reseed_bist_seq_bench.sv
module reseed_bist_seq_bench;
    localparam int W = 8;
    localparam int N = 4;
    localparam int K = 5;
    localparam logic [W-1:0]   TAPS  = 8'hB8;
    localparam logic [N*W-1:0] SEEDS = {8'h3C, 8'hE7, 8'h12, 8'h81};
    localparam int N2 = 3;
    localparam logic [N2*W-1:0] SEEDS2 = {8'h44, 8'h9D, 8'h07};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic k_start = 1'b0;
    logic [W-1:0] pattern, k_pat;
    logic valid, done, k_valid, k_done;
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    reseed_bist_seq #(.PAT_W(W), .SEED_CNT(N), .GROUP_LEN(K),
                      .TAP_MASK(TAPS), .SEED_TABLE(SEEDS)) u_reseed_bist_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .pattern_o(pattern), .valid_o(valid), .done_o(done));

    reseed_bist_seq #(.PAT_W(W), .SEED_CNT(N2), .GROUP_LEN(1),
                      .TAP_MASK(TAPS), .SEED_TABLE(SEEDS2)) u_reseed_bist_seq_k1 (
        .clk(clk), .rst_n(rst_n), .start_i(k_start),
        .pattern_o(k_pat), .valid_o(k_valid), .done_o(k_done));

    function automatic logic [W-1:0] step(input logic [W-1:0] p);
        return {p[W-2:0], ^(p & TAPS)};
    endfunction

    function automatic logic [W-1:0] seed(input int i);
        return SEEDS[i*W +: W];
    endfunction

    task automatic tick;
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input string tag, input logic [W+1:0] got, input logic [W+1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Full run from launch to done; optional start pulse in mid-run (R8)
    task automatic run_seq(input string first_tag, input bit poke);
        logic [W-1:0] exp;
        logic [W-1:0] last;
        start = 1'b1;
        tick();
        start = 1'b0;
        exp = seed(0);
        last = exp;
        for (int g = 0; g < N; g++) begin
            for (int j = 0; j < K; j++) begin
                if (g == 0 && j == 0)      chk(first_tag, {valid, done, pattern}, {2'b10, exp});
                else if (poke && g >= 1)   chk("R8", {valid, done, pattern}, {2'b10, exp});
                else if (j == 0)           chk("R5", {valid, done, pattern}, {2'b10, exp});
                else if (j == K - 1)       chk("R4", {valid, done, pattern}, {2'b10, exp});
                else                       chk("R3", {valid, done, pattern}, {2'b10, exp});
                last = exp;
                if (poke && g == 1 && j == 2) start = 1'b1;
                tick();
                start = 1'b0;
                exp = (j == K - 1) ? ((g < N - 1) ? seed(g + 1) : exp) : step(exp);
            end
        end
        chk("R6", {valid, done, pattern}, {2'b01, last});
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R7", {valid, done, pattern}, {2'b01, last});
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 0);
        $finish;
    end

    initial begin
        tick();
        tick();
        chk("R1", {valid, done, pattern}, '0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R1", {valid, done, pattern}, '0);
        end

        // Launch from IDLE with a start pulse in mid-run
        run_seq("R2", 1'b1);
        // Launch again from DONE
        run_seq("R9", 1'b0);

        // Reset in mid-run
        start = 1'b1;
        tick();
        start = 1'b0;
        tick();
        tick();
        rst_n = 1'b0;
        tick();
        chk("R10", {valid, done, pattern}, '0);
        rst_n = 1'b1;
        tick();
        chk("R10", {valid, done, pattern}, '0);
        run_seq("R10", 1'b0);

        // Group length of one: every pattern is a seed
        k_start = 1'b1;
        tick();
        k_start = 1'b0;
        for (int i = 0; i < N2; i++) begin
            chk("R5", {k_valid, k_done, k_pat}, {2'b10, SEEDS2[i*W +: W]});
            tick();
        end
        chk("R6", {k_valid, k_done, k_pat}, {2'b01, SEEDS2[(N2-1)*W +: W]});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule